// File: doc/BRIEF.md
# Battery Monitor Power-Mode Sequencer

This block decides when a battery monitor runs a full measurement pass. Three modes are supported: a run mode, a low-power doze mode and an off mode. In run mode it emits a one-cycle measurement strobe once per second, using a prescaler that divides the system clock. In doze mode the strobe repeats every N seconds, where N is a programmable interval. Between strobes the rest of the monitor may idle. Two gate enables tell the surrounding logic whether the pass transistors stay on and whether the full-rate clock domain is needed.

Doze mode ends when a signed current sample goes past a programmable wake level, in either direction, for several valid samples in a row. It also ends at once when the fault flag is raised. Off mode ignores the current path and the fault flag. Only a rising edge on the pack-voltage-present input brings the block out of off mode, and it always returns to run mode. A host asks for doze or off through request inputs. A doze request is refused while a fault is active.

The sample unit is 0.25 mV of sense voltage. Each 2-bit level code selects one of four wake levels. Under the default debounce of three samples at a sample rate near one millisecond, the wake response stays inside the 1 ms to 10 ms window.

Top module: `pm_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, mode is run (code 2'b00), the strobe is low, and both `fet_en` and `clk_en` are high.
- R2: In run mode `meas_strobe` is a single-cycle pulse repeating every TICKS_PER_SEC clock cycles.
- R3: In doze mode (code 2'b01), consecutive strobes are max(`sleep_secs`,1) × TICKS_PER_SEC cycles apart, so a value of 0 behaves as 1 second.
- R4: A `sleep_req` in run mode moves the block to doze mode one cycle later. A `sleep_req` is ignored while `fault` is high.
- R5: `wake_sel` codes 0, 1, 2 and 3 select wake levels of 4, 9, 18 and 36 sample units (1.00, 2.25, 4.5 and 9 mV). A sample counts only when its magnitude is strictly greater than the level.
- R6: Wake detection is bipolar: a sample above +level or below −level both count.
- R7: Wake needs DEBOUNCE consecutive counting valid samples. A valid sample that does not count restarts the run. Mode returns to run one cycle after the last counting sample is taken.
- R8: A high `fault` in doze mode returns the block to run mode one cycle later.
- R9: A `shdn_req` in run or doze mode enters off mode (code 2'b10) one cycle later. It has priority over a simultaneous fault, wake or doze request.
- R10: In off mode there is no strobe and both gate enables are low. Current samples, fault and doze requests are ignored.
- R11: Only a rising edge of `pack_present` leaves off mode, and the block enters run mode one cycle later. A level that is already high does not count as an edge. The first strobe follows within TICKS_PER_SEC cycles of entry.
- R12: In doze mode `fet_en` is high and `clk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_valid | input | 1 | Current sample valid strobe |
| cur_sample | input | SAMPLE_W | Signed current sample, 0.25 mV units |
| wake_sel | input | 2 | Wake level code |
| sleep_secs | input | IV_W | Doze strobe interval in seconds |
| sleep_req | input | 1 | Host request to enter doze mode |
| shdn_req | input | 1 | Host request to enter off mode |
| fault | input | 1 | Fault condition flag |
| pack_present | input | 1 | Pack voltage detected at startup level |
| mode | output | 2 | Current mode: 00 run, 01 doze, 10 off |
| meas_strobe | output | 1 | Measurement pass strobe |
| fet_en | output | 1 | Pass transistor gate enable |
| clk_en | output | 1 | Full-rate clock domain enable |

## Verification
Some rules are checked by the embedded properties on every cycle. Off mode holds until pack voltage appears. A fault blocks entry to doze. An off request wins over all else. Doze is left only after a fault or a wake. Run-mode strobes coincide with prescaler ticks. The exact strobe spacing in both modes, the strict edge of each wake level, the reset of the debounce run and the rule that a level already high does not count as an edge depend on counted cycle gaps and chosen sample sequences. Only the directed scenarios of the bench can show those.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_DOZE = 2'b01,
        PM_OFF  = 2'b10
    } pm_mode_e;

    typedef struct packed {
        logic fet_en;
        logic clk_en;
    } pm_gates_t;

    // Wake levels in 0.25 mV sample units, ascending with the code.
    function automatic int unsigned wake_level(input logic [1:0] code);
        case (code)
            2'd0:    return 4;
            2'd1:    return 9;
            2'd2:    return 18;
            default: return 36;
        endcase
    endfunction

endpackage

// File: rtl/pm_sec_tick.sv
module pm_sec_tick #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);  // R2

endmodule

// File: rtl/pm_wake_detect.sv
module pm_wake_detect
    import pm_seq_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DEBOUNCE = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [1:0]                 sel,
    output logic                       wake
);
    localparam int DW = $clog2(DEBOUNCE + 1);
    localparam logic [DW-1:0] FULL = DW'(DEBOUNCE);

    logic signed [SAMPLE_W:0] s_ext;
    logic signed [SAMPLE_W:0] lim;
    logic                     over;
    logic [DW-1:0]            run_cnt;

    always_comb begin
        s_ext = {sample[SAMPLE_W-1], sample};
        lim   = signed'((SAMPLE_W+1)'(wake_level(sel)));
        over  = (s_ext > lim) || (s_ext < -lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            run_cnt <= '0;
        else if (valid) begin
            if (!over)
                run_cnt <= '0;
            else if (run_cnt != FULL)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign wake = en && (run_cnt == FULL);

    AST_WAKE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> $past(valid));  // R7

endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
    import pm_seq_pkg::*;
#(
    parameter int IV_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            wake,
    input  logic            fault,
    input  logic            sleep_req,
    input  logic            shdn_req,
    input  logic            pack_present,
    input  logic [IV_W-1:0] sleep_secs,
    output pm_mode_e        mode,
    output logic            strobe,
    output pm_gates_t       gates
);
    pm_mode_e        mode_nx;
    logic            pack_q;
    logic            pack_rise;
    logic [IV_W-1:0] iv;
    logic [IV_W-1:0] iv_last;
    logic [IV_W-1:0] doze_cnt;
    logic            doze_due;

    assign pack_rise = pack_present && !pack_q;
    assign iv        = (sleep_secs == '0) ? IV_W'(1) : sleep_secs;
    assign iv_last   = iv - 1'b1;
    assign doze_due  = (doze_cnt >= iv_last);

    always_comb begin
        mode_nx = mode;
        case (mode)
            PM_RUN: begin
                if (shdn_req)                mode_nx = PM_OFF;
                else if (sleep_req && !fault) mode_nx = PM_DOZE;
            end
            PM_DOZE: begin
                if (shdn_req)          mode_nx = PM_OFF;
                else if (fault || wake) mode_nx = PM_RUN;
            end
            default: begin
                if (pack_rise) mode_nx = PM_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= PM_RUN;
            pack_q <= 1'b0;
        end else begin
            mode   <= mode_nx;
            pack_q <= pack_present;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mode != PM_DOZE)
            doze_cnt <= '0;
        else if (tick)
            doze_cnt <= doze_due ? '0 : doze_cnt + 1'b1;
    end

    always_comb begin
        case (mode)
            PM_RUN:  begin strobe = tick;             gates = '{fet_en: 1'b1, clk_en: 1'b1}; end
            PM_DOZE: begin strobe = tick && doze_due; gates = '{fet_en: 1'b1, clk_en: 1'b0}; end
            default: begin strobe = 1'b0;             gates = '{fet_en: 1'b0, clk_en: 1'b0}; end
        endcase
    end

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_OFF && !pack_present) |=> mode == PM_OFF);  // R11

    AST_FAULT_BLOCKS_DOZE: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_RUN && fault) |=> mode != PM_DOZE);  // R4

    AST_DOZE_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_RUN && $past(mode) == PM_DOZE) |-> $past(fault || wake));  // R8

    AST_SHDN_WINS: assert property (@(posedge clk) disable iff (rst)
        (mode != PM_OFF && shdn_req) |=> mode == PM_OFF);  // R9

    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        strobe |-> tick);  // R2

endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
    import pm_seq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SAMPLE_W      = 16,
    parameter int IV_W          = 8,
    parameter int DEBOUNCE      = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cur_valid,
    input  logic signed [SAMPLE_W-1:0] cur_sample,
    input  logic [1:0]                 wake_sel,
    input  logic [IV_W-1:0]            sleep_secs,
    input  logic                       sleep_req,
    input  logic                       shdn_req,
    input  logic                       fault,
    input  logic                       pack_present,
    output logic [1:0]                 mode,
    output logic                       meas_strobe,
    output logic                       fet_en,
    output logic                       clk_en
);
    pm_mode_e  mode_q;
    pm_gates_t gates;
    logic      tick;
    logic      wake;

    pm_sec_tick #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (mode_q != PM_OFF),
        .tick (tick)
    );

    pm_wake_detect #(.SAMPLE_W(SAMPLE_W), .DEBOUNCE(DEBOUNCE)) u_wake (
        .clk    (clk),
        .rst    (rst),
        .en     (mode_q == PM_DOZE),
        .valid  (cur_valid),
        .sample (cur_sample),
        .sel    (wake_sel),
        .wake   (wake)
    );

    pm_mode_ctrl #(.IV_W(IV_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .wake         (wake),
        .fault        (fault),
        .sleep_req    (sleep_req),
        .shdn_req     (shdn_req),
        .pack_present (pack_present),
        .sleep_secs   (sleep_secs),
        .mode         (mode_q),
        .strobe       (meas_strobe),
        .gates        (gates)
    );

    assign mode   = mode_q;
    assign fet_en = gates.fet_en;
    assign clk_en = gates.clk_en;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |-> (!meas_strobe && !fet_en && !clk_en));  // R10

endmodule

// File: tb/pm_sequencer_test.sv
`timescale 1ns/1ps
module pm_sequencer_test;
    localparam int TPS = 20;
    localparam int SW  = 16;
    localparam int IW  = 8;
    localparam int DEB = 3;
    localparam logic [1:0] M_RUN = 2'b00, M_DOZE = 2'b01, M_OFF = 2'b10;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cur_valid = 1'b0;
    logic signed [SW-1:0] cur_sample = '0;
    logic [1:0]           wake_sel = 2'd0;
    logic [IW-1:0]        sleep_secs = 8'd1;
    logic                 sleep_req = 1'b0;
    logic                 shdn_req = 1'b0;
    logic                 fault = 1'b0;
    logic                 pack_present = 1'b0;
    logic [1:0]           mode;
    logic                 meas_strobe;
    logic                 fet_en;
    logic                 clk_en;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pm_sequencer #(.TICKS_PER_SEC(TPS), .SAMPLE_W(SW), .IV_W(IW), .DEBOUNCE(DEB)) uut (
        .clk(clk), .rst(rst), .cur_valid(cur_valid), .cur_sample(cur_sample),
        .wake_sel(wake_sel), .sleep_secs(sleep_secs), .sleep_req(sleep_req),
        .shdn_req(shdn_req), .fault(fault), .pack_present(pack_present),
        .mode(mode), .meas_strobe(meas_strobe), .fet_en(fet_en), .clk_en(clk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int val);
        cur_valid  = 1'b1;
        cur_sample = SW'(val);
        step(1);
        cur_valid  = 1'b0;
    endtask

    task automatic enter_doze();
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
    endtask

    task automatic leave_by_fault();
        fault = 1'b1;
        step(1);
        fault = 1'b0;
    endtask

    task automatic strobe_gap(output int gap);
        int guard = 0;
        while (!meas_strobe && guard < 5000) begin step(1); guard++; end
        gap = 0;
        do begin step(1); gap++; end while (!meas_strobe && gap < 5000);
    endtask

    task automatic t_reset();
        check("R1 mode in reset", mode, M_RUN);
        check("R1 strobe in reset", meas_strobe, 0);
        rst = 1'b0;
        step(1);
        check("R1 mode after reset", mode, M_RUN);
        check("R1 fet_en", fet_en, 1);
        check("R1 clk_en", clk_en, 1);
    endtask

    task automatic t_run_period();
        int g;
        strobe_gap(g);
        check("R2 run strobe gap", g, TPS);
        step(1);
        check("R2 strobe single cycle", meas_strobe, 0);
    endtask

    task automatic t_doze_entry();
        fault = 1'b1; sleep_req = 1'b1;
        step(2);
        check("R4 doze refused under fault", mode, M_RUN);
        fault = 1'b0; sleep_req = 1'b0;
        enter_doze();
        check("R4 doze entry", mode, M_DOZE);
        check("R12 doze fet_en", fet_en, 1);
        check("R12 doze clk_en", clk_en, 0);
        leave_by_fault();
        check("R8 fault wakes", mode, M_RUN);
    endtask

    task automatic t_doze_interval(input int secs);
        int g;
        sleep_secs = IW'(secs);
        enter_doze();
        strobe_gap(g);
        check("R3 doze strobe gap", g, ((secs == 0) ? 1 : secs) * TPS);
        leave_by_fault();
    endtask

    task automatic t_levels();
        int lv[4] = '{4, 9, 18, 36};
        for (int c = 0; c < 4; c++) begin
            wake_sel = 2'(c);
            enter_doze();
            repeat (DEB) send(lv[c]);
            step(1);
            check("R5 level not exceeded", mode, M_DOZE);
            repeat (DEB) send(lv[c] + 1);
            step(1);
            check("R5 level exceeded wakes", mode, M_RUN);
        end
    endtask

    task automatic t_bipolar();
        wake_sel = 2'd2;
        enter_doze();
        repeat (DEB) send(-18);
        step(1);
        check("R6 negative at level holds", mode, M_DOZE);
        send(-19); send(25); send(-40);
        step(1);
        check("R6 mixed-sign excursion wakes", mode, M_RUN);
    endtask

    task automatic t_debounce();
        wake_sel = 2'd0;
        enter_doze();
        send(5); send(5); send(0); send(5); send(5);
        step(2);
        check("R7 broken run holds", mode, M_DOZE);
        send(5);
        check("R7 mode on last sample", mode, M_DOZE);
        step(1);
        check("R7 wake one cycle later", mode, M_RUN);
    endtask

    task automatic t_off();
        int strobes = 0;
        int n = 0;
        pack_present = 1'b1;
        shdn_req = 1'b1;
        step(1);
        shdn_req = 1'b0;
        check("R9 shutdown from run", mode, M_OFF);
        check("R10 off fet_en", fet_en, 0);
        check("R10 off clk_en", clk_en, 0);
        fault = 1'b1; sleep_req = 1'b1;
        repeat (DEB + 1) send(1000);
        fault = 1'b0; sleep_req = 1'b0;
        for (int i = 0; i < 3 * TPS; i++) begin
            if (meas_strobe) strobes++;
            step(1);
        end
        check("R10 no strobe in off", strobes, 0);
        check("R11 held-high pack ignored", mode, M_OFF);
        pack_present = 1'b0;
        step(2);
        pack_present = 1'b1;
        step(1);
        check("R11 pack rise enters run", mode, M_RUN);
        while (!meas_strobe && n < 5000) begin step(1); n++; end
        check("R11 strobe within one tick", int'(n <= TPS), 1);
        pack_present = 1'b0;
    endtask

    task automatic t_priority();
        enter_doze();
        fault = 1'b1; shdn_req = 1'b1;
        step(1);
        fault = 1'b0; shdn_req = 1'b0;
        check("R9 shutdown beats fault", mode, M_OFF);
        step(1);
        pack_present = 1'b1;
        step(1);
        pack_present = 1'b0;
        check("R11 recovery", mode, M_RUN);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; failed++;
            $display("FAIL watchdog R1-flow: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        step(3);
        t_reset();
        t_run_period();
        t_doze_entry();
        t_doze_interval(3);
        t_doze_interval(0);
        t_doze_interval(1);
        t_levels();
        t_bipolar();
        t_debounce();
        t_off();
        t_priority();
        done = 1'b1;
        finish_up();
    end

endmodule